// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block decides when a successive-approximation converter samples its input and when it resolves it. A CPU programs one 8-bit control register that enables the converter, chooses which event starts a conversion, and optionally asks for a short extra tracking phase before each conversion. The block watches the chosen trigger: a software write, one of four timer overflow pulses, or a rising edge on an external pin. When the trigger fires it drives the busy, track and convert outputs toward the converter until the converter reports completion.

Two sticky flags record events for software. One is the conversion-complete flag and the other is the window-match flag. Each stays set until software writes a 0 to it. The bit cycling of the converter, the analog front end and the window comparison arithmetic live outside this block. The block only sees their clock-enable, done and match pulses.

Top module: `adc_start_seq`

## Requirements
- R1: After reset the control register reads 0x00, and busy, track and convert are all 0.
- R2: While the enable bit (bit 7) is 0, track stays 0 and every start trigger is ignored. Clearing enable during a conversion returns the block to idle on the next clock, so busy reads 0.
- R3: The start-source field (bits 2:0) selects the trigger. The encodings are 001 for timer_ovf[0], 011 for timer_ovf[1], 010 for timer_ovf[2] and 101 for timer_ovf[3]. Overflow pulses on timers that are not selected start nothing.
- R4: With source 000, a register write with bit 4 = 1 and bits 2:0 = 000 starts a conversion, and busy reads 1 from the second clock after the write. A write with bit 4 = 1 under any other source, or a write with bit 4 = 0, starts nothing.
- R5: With source 100, the external pin passes through two synchronizing flip-flops and an edge detector. If the pin rises before clock edge E0, busy becomes 1 after edge E0+2. A pin held high does not start again.
- R6: When the track-mode bit (bit 6) is 0, track is 1 whenever the block is enabled and not converting. Convert rises on the clock after the start event.
- R7: When bit 6 is 1, a start event keeps track at 1 and convert at 0 for exactly three sar_clk_en pulses. Convert rises on the clock that samples the third pulse.
- R8: Busy (register bit 4, and the busy port) is 1 from the start event until the clock that samples conv_done during conversion. After that, the block is idle and tracking again.
- R9: While busy, further start events are ignored. A conv_done pulse outside the conversion phase is also ignored.
- R10: The completion flag (bit 5) is set by conv_done during conversion, stays set, and is cleared only by a register write with bit 5 = 0.
- R11: The window flag (bit 3) is set by a win_match pulse, stays set, and is cleared only by a register write with bit 3 = 0.
- R12: When a flag set and a software clear of that flag happen in the same cycle, the flag ends up set.
- R13: Reserved source values 110 and 111 never start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write value |
| reg_rd_data | output | 8 | Control register read value (bit 4 is live busy) |
| timer_ovf | input | 4 | Timer overflow pulses, index = timer number |
| ext_start_pin | input | 1 | Asynchronous external convert-start pin |
| sar_clk_en | input | 1 | One-cycle pulse per converter clock |
| conv_done | input | 1 | Conversion finished pulse |
| win_match | input | 1 | Window comparison match pulse |
| busy | output | 1 | A start has been accepted and the conversion is not yet done |
| track | output | 1 | Converter input should track |
| convert | output | 1 | Converter should run its bit cycling |

## Verification
A phase register left in the wrong state shows up at once on busy, track or convert, and on read bit 4, within the clock after the fault. An extended-tracking counter that is off by one moves the rise of convert by one converter clock. A wrong source decode either leaves busy low after a selected overflow or raises it after an unselected one, on the very next edge. A fault in a flag appears in the read value one clock after the offending pulse or write. The behavioural model compares every output on every cycle, so each of these shows up within one or two clocks.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [2:0] {
        SRC_SWBUSY = 3'b000,
        SRC_TMR0   = 3'b001,
        SRC_TMR2   = 3'b010,
        SRC_TMR1   = 3'b011,
        SRC_EXTPIN = 3'b100,
        SRC_TMR3   = 3'b101,
        SRC_RSV6   = 3'b110,
        SRC_RSV7   = 3'b111
    } start_src_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_XTRACK = 2'd1,
        PH_CONV   = 2'd2
    } phase_e;

    // Stored configuration (busy is live, not stored)
    typedef struct packed {
        logic       enable;
        logic       delay_trk;
        start_src_e src;
    } ctrl_cfg_t;

    typedef struct packed {
        logic done;
        logic win;
    } ctrl_flags_t;

    // Bit positions of the control register
    localparam int B_EN   = 7;
    localparam int B_DTRK = 6;
    localparam int B_DONE = 5;
    localparam int B_BUSY = 4;
    localparam int B_WIN  = 3;

    function automatic logic src_is_reserved(input start_src_e s);
        return (s == SRC_RSV6) || (s == SRC_RSV7);
    endfunction

    function automatic logic src_is_timer(input start_src_e s);
        return (s == SRC_TMR0) || (s == SRC_TMR1) || (s == SRC_TMR2) || (s == SRC_TMR3);
    endfunction

    // Timer number selected by a source code
    function automatic int timer_index(input start_src_e s);
        case (s)
            SRC_TMR0: return 0;
            SRC_TMR1: return 1;
            SRC_TMR2: return 2;
            SRC_TMR3: return 3;
            default:  return -1;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_ctrl_reg.sv
module adc_seq_ctrl_reg
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              busy,
    input  logic              done_set,
    input  logic              win_set,
    output ctrl_cfg_t         cfg,
    output logic [CTRL_W-1:0] rd_data,
    output logic              sw_start
);

    ctrl_flags_t flags_q;
    logic        sw_start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{enable: 1'b0, delay_trk: 1'b0, src: SRC_SWBUSY};
        end else if (wr_en) begin
            cfg.enable    <= wr_data[B_EN];
            cfg.delay_trk <= wr_data[B_DTRK];
            cfg.src       <= start_src_e'(wr_data[2:0]);
        end
    end

    // Hardware set has priority over a software write of zero
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.done <= done_set | (wr_en ? wr_data[B_DONE] : flags_q.done);
            flags_q.win  <= win_set  | (wr_en ? wr_data[B_WIN]  : flags_q.win);
        end
    end

    // Software start request: a busy-bit write of 1 with source field 000
    always_ff @(posedge clk) begin
        if (rst) sw_start_q <= 1'b0;
        else     sw_start_q <= wr_en & wr_data[B_BUSY] & (wr_data[2:0] == SRC_SWBUSY);
    end

    assign sw_start = sw_start_q;
    assign rd_data  = {cfg.enable, cfg.delay_trk, flags_q.done, busy, flags_q.win, cfg.src};

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done_set |=> rd_data[B_DONE]); // R10
    AST_WIN_STICKY: assert property (@(posedge clk) disable iff (rst)
        win_set |=> rd_data[B_WIN]); // R11
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (win_set && wr_en && !wr_data[B_WIN]) |=> rd_data[B_WIN]); // R12
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rd_data[B_DONE] && !wr_en) |=> rd_data[B_DONE]); // R10

endmodule

// File: rtl/adc_seq_trig_sel.sv
module adc_seq_trig_sel
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_TIMERS  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ctrl_cfg_t             cfg,
    input  logic                  sw_start,
    input  logic [NUM_TIMERS-1:0] timer_ovf,
    input  logic                  ext_pin,
    output logic                  start_req
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_prev_q;
    logic                   pin_rise;
    logic [NUM_TIMERS-1:0]  tmr_mask;
    logic                   tmr_hit;
    logic                   hit;

    // Synchronizer chain for the asynchronous pin
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b0;
                else     sync_q[0] <= ext_pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pin_prev_q <= 1'b0;
        else     pin_prev_q <= sync_q[LAST];
    end

    assign pin_rise = sync_q[LAST] & ~pin_prev_q;

    // One-hot mask of the selected timer
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmask
        assign tmr_mask[t] = src_is_timer(cfg.src) && (timer_index(cfg.src) == t);
    end

    assign tmr_hit = |(timer_ovf & tmr_mask);

    always_comb begin
        hit = 1'b0;
        if (cfg.src == SRC_SWBUSY)      hit = sw_start;
        else if (cfg.src == SRC_EXTPIN) hit = pin_rise;
        else if (src_is_timer(cfg.src)) hit = tmr_hit;
    end

    assign start_req = cfg.enable & hit;

    AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tmr_mask)); // R3
    AST_PIN_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pin_rise |=> !pin_rise); // R5

endmodule

// File: rtl/adc_seq_phase_fsm.sv
module adc_seq_phase_fsm
    import adc_seq_pkg::*;
#(
    parameter int XTRACK_CLKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic delay_trk,
    input  logic start_req,
    input  logic sar_clk_en,
    input  logic conv_done,
    output logic busy,
    output logic track,
    output logic convert,
    output logic done_pulse
);

    localparam int CNT_W = $clog2(XTRACK_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XTRACK_CLKS - 1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (!enable) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_req) begin
                        phase_d = delay_trk ? PH_XTRACK : PH_CONV;
                        cnt_d   = '0;
                    end
                end
                PH_XTRACK: begin
                    if (sar_clk_en) begin
                        if (cnt_q == CNT_LAST) phase_d = PH_CONV;
                        else                   cnt_d   = cnt_q + 1'b1;
                    end
                end
                PH_CONV: begin
                    if (conv_done) phase_d = PH_IDLE;
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign busy       = (phase_q != PH_IDLE);
    assign convert    = (phase_q == PH_CONV);
    assign track      = enable & (phase_q != PH_CONV);
    assign done_pulse = (phase_q == PH_CONV) & conv_done;

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy && enable && !conv_done) |=> busy); // R8
    AST_XTRACK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && enable && start_req && delay_trk) |=> (track && !convert)); // R7
    AST_NORMAL_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && enable && start_req && !delay_trk) |=> convert); // R6
    AST_CONV_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (convert && enable && !conv_done) |=> convert); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST); // R7

endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int XTRACK_CLKS = 3,
    parameter int NUM_TIMERS  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr_en,
    input  logic [7:0]            reg_wr_data,
    output logic [7:0]            reg_rd_data,
    input  logic [NUM_TIMERS-1:0] timer_ovf,
    input  logic                  ext_start_pin,
    input  logic                  sar_clk_en,
    input  logic                  conv_done,
    input  logic                  win_match,
    output logic                  busy,
    output logic                  track,
    output logic                  convert
);

    ctrl_cfg_t cfg;
    logic      sw_start;
    logic      start_req;
    logic      done_pulse;

    adc_seq_ctrl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .busy     (busy),
        .done_set (done_pulse),
        .win_set  (win_match),
        .cfg      (cfg),
        .rd_data  (reg_rd_data),
        .sw_start (sw_start)
    );

    adc_seq_trig_sel #(
        .SYNC_STAGES (SYNC_STAGES),
        .NUM_TIMERS  (NUM_TIMERS)
    ) u_trig (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .sw_start  (sw_start),
        .timer_ovf (timer_ovf),
        .ext_pin   (ext_start_pin),
        .start_req (start_req)
    );

    adc_seq_phase_fsm #(
        .XTRACK_CLKS (XTRACK_CLKS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (cfg.enable),
        .delay_trk  (cfg.delay_trk),
        .start_req  (start_req),
        .sar_clk_en (sar_clk_en),
        .conv_done  (conv_done),
        .busy       (busy),
        .track      (track),
        .convert    (convert),
        .done_pulse (done_pulse)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_data[B_EN] |=> !busy); // R2
    AST_RSV_NO_START: assert property (@(posedge clk) disable iff (rst)
        (src_is_reserved(start_src_e'(reg_rd_data[2:0])) && !busy) |=> !busy); // R13
    AST_BUSY_READBACK: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[B_BUSY] == busy); // R8

endmodule

// File: tb/adc_start_seq_tb_top.sv
module adc_start_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;
    logic [3:0] timer_ovf;
    logic       ext_start_pin;
    logic       sar_clk_en;
    logic       conv_done;
    logic       win_match;
    logic       busy, track, convert;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit ended  = 0;
    string req = "R1";

    always #2 clk = ~clk;

    adc_start_seq dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .timer_ovf(timer_ovf), .ext_start_pin(ext_start_pin),
        .sar_clk_en(sar_clk_en), .conv_done(conv_done), .win_match(win_match),
        .busy(busy), .track(track), .convert(convert)
    );

    // Behavioural reference model
    bit m_en, m_tm, m_done, m_win, m_swp, m_live;
    bit [2:0] m_mode;
    int m_st, m_cnt;   // 0 idle, 1 extra tracking, 2 converting
    bit pin_hist[$];   // [0],[1] synchronizer, [2] previous value

    always @(posedge clk) begin
        bit rise, trig, dset;
        if (rst) begin
            m_en = 0; m_tm = 0; m_done = 0; m_win = 0; m_swp = 0;
            m_mode = 0; m_st = 0; m_cnt = 0; m_live = 1;
            pin_hist = {1'b0, 1'b0, 1'b0};
        end else begin
            rise = pin_hist[1] && !pin_hist[2];
            case (m_mode)
                3'd0: trig = m_swp;
                3'd1: trig = timer_ovf[0];
                3'd2: trig = timer_ovf[2];
                3'd3: trig = timer_ovf[1];
                3'd4: trig = rise;
                3'd5: trig = timer_ovf[3];
                default: trig = 0;
            endcase
            dset = (m_st == 2) && conv_done;
            if (!m_en) begin
                m_st = 0; m_cnt = 0;
            end else if (m_st == 0) begin
                if (trig) begin m_st = m_tm ? 1 : 2; m_cnt = 0; end
            end else if (m_st == 1) begin
                if (sar_clk_en) begin
                    m_cnt++;
                    if (m_cnt == 3) m_st = 2;
                end
            end else if (conv_done) begin
                m_st = 0;
            end
            if (reg_wr_en) begin
                m_en = reg_wr_data[7]; m_tm = reg_wr_data[6];
                m_done = reg_wr_data[5]; m_win = reg_wr_data[3];
                m_mode = reg_wr_data[2:0];
            end
            if (dset) m_done = 1;
            if (win_match) m_win = 1;
            m_swp = reg_wr_en && reg_wr_data[4] && (reg_wr_data[2:0] == 3'd0);
            pin_hist.push_front(ext_start_pin);
            void'(pin_hist.pop_back());
        end
    end

    task automatic check(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && m_live && !ended) begin
            check("rd_data", reg_rd_data,
                  {m_en, m_tm, m_done, (m_st != 0), m_win, m_mode});
            check("busy", busy, m_st != 0);
            check("track", track, m_en && m_st != 2);
            check("convert", convert, m_st == 2);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input bit en, input bit tm, input bit dn, input bit bz, input bit wn, input bit [2:0] md);
        reg_wr_en = 1; reg_wr_data = {en, tm, dn, bz, wn, md};
        step();
        reg_wr_en = 0; reg_wr_data = 0;
    endtask

    task automatic tmr(input int i);
        timer_ovf[i] = 1; step(); timer_ovf = 0;
    endtask

    task automatic finish_conv();
        conv_done = 1; step(); conv_done = 0; step();
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst = 1; reg_wr_en = 0; reg_wr_data = 0; timer_ovf = 0;
        ext_start_pin = 0; sar_clk_en = 0; conv_done = 0; win_match = 0;
        repeat (3) step();
        rst = 0; step();

        req = "R1";
        check("reset rd", reg_rd_data, 8'h00);
        check("reset busy", busy, 0);
        check("reset track", track, 0);

        req = "R2";
        wr(0, 0, 0, 0, 0, 3'd1);
        tmr(0); step();
        check("disabled busy", busy, 0);
        check("disabled track", track, 0);
        wr(0, 0, 0, 1, 0, 3'd0); step(); step();
        check("disabled sw start", busy, 0);

        req = "R6";
        wr(1, 0, 0, 0, 0, 3'd1);
        check("idle track", track, 1);
        tmr(0);
        check("direct convert", convert, 1);
        check("track off in conv", track, 0);

        req = "R9";
        tmr(0); tmr(1); step();
        check("still converting", convert, 1);
        finish_conv();
        req = "R8";
        check("idle after done", busy, 0);
        check("tracking after done", track, 1);
        req = "R10";
        check("done flag", reg_rd_data[5], 1);
        repeat (3) step();
        check("done flag sticky", reg_rd_data[5], 1);
        req = "R9";
        conv_done = 1; step(); conv_done = 0; step();
        check("stray done ignored", busy, 0);

        req = "R3";
        for (int m = 1; m <= 5; m++) begin
            if (m == 4) continue;
            wr(1, 0, 0, 0, 0, 3'(m));
            for (int t = 0; t < 4; t++) begin
                tmr(t); step();
                if (busy) finish_conv();
            end
        end
        wr(1, 0, 0, 0, 0, 3'd3);
        tmr(0); tmr(2); tmr(3); step();
        check("unselected timers", busy, 0);
        tmr(1);
        check("timer1 selected", busy, 1);
        finish_conv();

        req = "R4";
        wr(1, 0, 0, 1, 0, 3'd0);
        check("sw start one clk", busy, 0);
        step();
        check("sw start two clk", busy, 1);
        finish_conv();
        wr(1, 0, 0, 0, 0, 3'd0); step(); step();
        check("write busy 0", busy, 0);
        wr(1, 0, 0, 1, 0, 3'd1); step(); step();
        check("busy 1 other source", busy, 0);

        req = "R5";
        wr(1, 0, 0, 0, 0, 3'd4);
        ext_start_pin = 1;
        step(); step();
        check("pin sync delay", busy, 0);
        step();
        check("pin start", busy, 1);
        finish_conv();
        repeat (5) step();
        check("pin level no retrigger", busy, 0);
        ext_start_pin = 0; repeat (4) step();
        ext_start_pin = 1; repeat (4) step();
        check("pin second edge", busy, 1);
        finish_conv(); ext_start_pin = 0; repeat (4) step();

        req = "R7";
        wr(1, 1, 0, 0, 0, 3'd1);
        tmr(0);
        check("xtrack busy", busy, 1);
        check("xtrack track", track, 1);
        for (int k = 1; k <= 3; k++) begin
            step(); step();
            sar_clk_en = 1; step(); sar_clk_en = 0;
            check("xtrack convert", convert, k == 3);
        end
        finish_conv();
        tmr(0); sar_clk_en = 1; repeat (3) step(); sar_clk_en = 0;
        check("back-to-back clk enables", convert, 1);
        finish_conv();

        req = "R11";
        win_match = 1; step(); win_match = 0;
        check("win set", reg_rd_data[3], 1);
        repeat (4) step();
        check("win sticky", reg_rd_data[3], 1);
        wr(1, 1, 0, 0, 0, 3'd1);
        check("win cleared", reg_rd_data[3], 0);

        req = "R12";
        win_match = 1; wr(1, 0, 0, 0, 0, 3'd1); win_match = 0;
        check("win set beats clear", reg_rd_data[3], 1);
        tmr(0);
        conv_done = 1; wr(1, 0, 0, 0, 0, 3'd1); conv_done = 0;
        check("done set beats clear", reg_rd_data[5], 1);

        req = "R13";
        for (int m = 6; m <= 7; m++) begin
            wr(1, 0, 0, 1, 0, 3'(m));
            for (int t = 0; t < 4; t++) tmr(t);
            ext_start_pin = 1; repeat (4) step(); ext_start_pin = 0; repeat (3) step();
            check("reserved no start", busy, 0);
        end

        req = "R2";
        wr(1, 0, 0, 0, 0, 3'd5);
        tmr(3);
        check("conv before abort", convert, 1);
        wr(0, 0, 0, 0, 0, 3'd5);
        step();
        check("abort busy", busy, 0);
        check("abort track", track, 0);

        repeat (4) step();
        summary();
    end

endmodule